// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block filters a stream of signed two's-complement samples with a fixed set of coefficients and uses no multiplier. Each accepted sample enters a tap delay line. The block then walks through the sample bit positions, least significant first, one bit position per clock. At each position it takes that bit from every tap and uses the result as an address into small coefficient-sum tables. The table outputs are summed and folded into a shift-accumulator. At the most significant (sign) bit position the table sum is subtracted instead of added.

The taps are split into groups of four, and each group has its own table. The address bits are treated as ±1 values, which makes every table antisymmetric. Only the half selected by the group's top address bit is stored. That bit then chooses between adding and negating, and the lower bits are inverted when it is clear. A constant equal to the coefficient sum is removed at the end. Coefficients carry a scale of 2^16, and the final stage shifts the result back down with floor rounding.

The input side is a valid/ready pair. `in_ready` is high only while the engine is idle, so a sample is taken when `in_valid` and `in_ready` are both high at a clock edge. While the engine is busy, `in_ready` is low and whatever is presented on `in_data` is left alone. The output side has no back-pressure: the consumer must take `out_data` in the single cycle that `out_valid` is high. The value then stays on `out_data` until the next result.

Top module: `da_fir`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0.
- R2: A sample is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle on and stays 0 until the result appears.
- R3: While `in_ready` is 0, `in_valid` and `in_data` have no effect: such values never enter the tap line, and later outputs are unaffected by them.
- R4: `out_valid` rises exactly SMP_W clock edges after the accepting edge and lasts one cycle. `out_data` then holds its value until the next result, and `in_ready` is 1 in the cycle where `out_valid` is 1.
- R5: `out_data` equals floor((sum over k of COEFS[k] * x[n-k]) / 2^16) as a signed value. Here x[n] is the newest accepted sample, tap index 0 holds the newest sample, and tap index k holds the sample accepted k steps earlier.
- R6: Reset clears the tap line, so samples from before reset never contribute to a later output.
- R7: The most negative sample (-128 at SMP_W=8) and the most positive sample (127) are filtered exactly, which shows the negative weight of the sign-bit step.
- R8: Taps 0–3 and taps 4–7 are served by separate tables, and both groups contribute with the right coefficient. An isolated nonzero sample followed by zeros produces outputs floor(COEFS[k]*v/2^16) for k = 0..7 in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on `in_data` is offered |
| in_ready | output | 1 | Engine idle; an offered sample is taken at the next edge |
| in_data | input | SMP_W | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OUT_W | Signed filtered result, already shifted down by 16 |

## Verification
The bench uses the default build: eight taps of 8-bit samples, 18-bit coefficients and two groups of four taps, so each group has an eight-entry half table. The coefficients are deliberately asymmetric and mix signs, so an impulse exposes every tap position and both group boundaries. Swapped tap order, a wrong group base or a sign error in the folded half table each show up as a wrong value. With 8-bit samples, both extremes -128 and 127 can be reached by full step sequences. The bench also applies a short run of pseudo-random samples. The nine-cycle accept-to-accept cadence is short enough to offer spurious samples during the busy window and to reset in the middle of a computation.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Sample-engine state: waiting for a sample or stepping through its bits
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int TAPS  = 8,
  parameter int SMP_W = 8,
  localparam int SEL_W = $clog2(SMP_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [SMP_W-1:0] din,
  input  logic [SEL_W-1:0]        bit_sel,
  output logic [TAPS-1:0]         slice
);

  logic signed [SMP_W-1:0] taps_q [TAPS];

  // Newest sample lands in tap 0; older ones move one place along
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
    end else if (load) begin
      taps_q[0] <= din;
      for (int k = 1; k < TAPS; k++) taps_q[k] <= taps_q[k-1];
    end
  end

  // One bit of equal weight from every tap
  always_comb begin
    for (int k = 0; k < TAPS; k++) slice[k] = taps_q[k][bit_sel];
  end

  // R2
  load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (taps_q[0] == $past(din)) && (taps_q[1] == $past(taps_q[0])));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(taps_q[0]) && $stable(taps_q[TAPS-1]));

endmodule

// File: rtl/da_group_lut.sv
module da_group_lut #(
  parameter int COEF_W = 18,
  parameter int TAPS   = 8,
  parameter int LUT_IN = 4,
  parameter int BASE   = 0,
  parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{default: '0},
  localparam int ROW_W = COEF_W + $clog2(LUT_IN) + 1,
  localparam int HALF  = 1 << (LUT_IN - 1)
) (
  input  logic [LUT_IN-1:0]       addr,
  output logic signed [ROW_W-1:0] q
);

  // Entry j is the signed sum for an address whose top bit is 1; each
  // lower bit counts its coefficient as +1 when set and -1 when clear.
  function automatic logic signed [ROW_W-1:0] row_val(input int j);
    logic signed [ROW_W-1:0] s;
    logic signed [ROW_W-1:0] ck;
    s = ROW_W'(COEFS[BASE + LUT_IN - 1]);
    for (int k = 0; k < LUT_IN - 1; k++) begin
      ck = ROW_W'(COEFS[BASE + k]);
      if (((j >> k) & 1) != 0) s = s + ck;
      else                     s = s - ck;
    end
    return s;
  endfunction

  logic signed [ROW_W-1:0] half_rom [HALF];

  for (genvar j = 0; j < HALF; j++) begin : g_rom
    assign half_rom[j] = row_val(j);
  end

  logic [LUT_IN-2:0] idx;

  // Lower half of the address space is the negation of the upper half
  always_comb begin
    if (addr[LUT_IN-1]) begin
      idx = addr[LUT_IN-2:0];
      q   = half_rom[idx];
    end else begin
      idx = ~addr[LUT_IN-2:0];
      q   = -half_rom[idx];
    end
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
  parameter int TERM_W = 23,
  parameter int ACC_W  = 32,
  parameter int SMP_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     neg,
  input  logic signed [TERM_W-1:0] term,
  output logic signed [ACC_W-1:0]  acc_d
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] ext;

  // Each term is placed SMP_W-1 bits up, so right shifts drop only zeros
  always_comb begin
    ext = ACC_W'(term) <<< (SMP_W - 1);
    if (clr)       acc_d = '0;
    else if (step) acc_d = (acc_q >>> 1) + (neg ? -ext : ext);
    else           acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R2
  clr_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && step));

endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int SMP_W  = 8,
  parameter int COEF_W = 18,
  parameter int LUT_IN = 4,
  parameter int SCALE  = 16,
  parameter int OUT_W  = 13,
  parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{
    COEF_W'(3000),  COEF_W'(-7000), COEF_W'(21000), COEF_W'(60000),
    COEF_W'(45000), COEF_W'(12000), COEF_W'(-5000), COEF_W'(1500)}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int NGRP  = TAPS / LUT_IN;
  localparam int CNT_W = $clog2(SMP_W);
  localparam int ROW_W = COEF_W + $clog2(LUT_IN) + 1;
  localparam int SUM_W = ROW_W + $clog2(NGRP) + 1;
  localparam int ACC_W = SUM_W + SMP_W + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SMP_W - 1);

  function automatic logic signed [ACC_W-1:0] coef_total();
    logic signed [ACC_W-1:0] s;
    s = '0;
    for (int k = 0; k < TAPS; k++) s = s + ACC_W'(COEFS[k]);
    return s;
  endfunction

  localparam logic signed [ACC_W-1:0] OFFSET = coef_total();

  eng_state_e             state_q;
  logic [CNT_W-1:0]       bit_q;
  logic                   accept;
  logic                   busy;
  logic                   last;
  logic [TAPS-1:0]        slice;
  logic signed [ROW_W-1:0] grp_q [NGRP];
  logic signed [SUM_W-1:0] term;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] fin;

  assign busy     = (state_q == ENG_RUN);
  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign last     = busy && (bit_q == LAST_BIT);

  da_tap_line #(.TAPS(TAPS), .SMP_W(SMP_W)) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .din     (in_data),
    .bit_sel (bit_q),
    .slice   (slice)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    da_group_lut #(
      .COEF_W (COEF_W),
      .TAPS   (TAPS),
      .LUT_IN (LUT_IN),
      .BASE   (g * LUT_IN),
      .COEFS  (COEFS)
    ) u_lut (
      .addr (slice[g*LUT_IN +: LUT_IN]),
      .q    (grp_q[g])
    );
  end

  always_comb begin
    term = '0;
    for (int g = 0; g < NGRP; g++) term = term + SUM_W'(grp_q[g]);
  end

  da_shift_acc #(.TERM_W(SUM_W), .ACC_W(ACC_W), .SMP_W(SMP_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .step  (busy),
    .neg   (last),
    .term  (term),
    .acc_d (acc_d)
  );

  // Remove the coefficient-sum offset, undo the factor of two from the
  // +/-1 recoding, then drop the coefficient scale (floor rounding)
  assign fin = (acc_d - OFFSET) >>> (SCALE + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      bit_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        state_q <= ENG_RUN;
        bit_q   <= '0;
      end else if (busy) begin
        if (last) begin
          state_q   <= ENG_IDLE;
          out_valid <= 1'b1;
          out_data  <= fin[OUT_W-1:0];
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy) && ($past(bit_q) == LAST_BIT));

  // R4
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/da_fir_tb.sv
`timescale 1ns/1ps
module da_fir_tb;

  localparam int TAPS  = 8;
  localparam int SMP_W = 8;
  localparam int OUT_W = 13;
  localparam longint CF [TAPS] = '{3000, -7000, 21000, 60000, 45000, 12000, -5000, 1500};
  localparam int NVEC = 28;
  // impulse, full-scale positive step, full-scale negative step, mixed
  localparam logic signed [7:0] VEC [NVEC] = '{
    8'sd100, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0,
    8'sd127, 8'sd127, 8'sd127, 8'sd127, 8'sd127, 8'sd127, 8'sd127, 8'sd127,
    -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128,
    8'sd55, -8'sd73, 8'sd18, -8'sd1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SMP_W-1:0] in_data = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  longint hist [TAPS];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  da_fir u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .out_valid (out_valid), .out_data (out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint got();
    return longint'($signed(out_data));
  endfunction

  function automatic longint model_out();
    longint s;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += CF[k] * hist[k];
    return s >>> 16;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
  endtask

  // Offer one sample; optionally offer junk through the busy window (R3)
  task automatic send(input logic signed [7:0] x, input bit junk, input string tag);
    longint e;
    @(negedge clk);
    check(out_valid == 1'b0, {"R4 idle strobe ", tag}, longint'(out_valid), 0);
    check(in_ready == 1'b1, {"R2 ready before ", tag}, longint'(in_ready), 1);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(x);
    e = model_out();
    in_valid = junk;
    in_data  = 8'sd77;
    check(in_ready == 1'b0, {"R2 busy after accept ", tag}, longint'(in_ready), 0);
    for (int i = 1; i <= SMP_W - 1; i++) begin
      @(negedge clk);
      if (out_valid != 1'b0) check(1'b0, {"R4 early strobe ", tag}, longint'(out_valid), 0);
      if (in_ready != 1'b0) check(1'b0, {"R2 ready too soon ", tag}, longint'(in_ready), 0);
      in_valid = junk && (i < SMP_W - 1);
      in_data  = (i[0]) ? 8'sd99 : -8'sd50;
    end
    @(negedge clk);
    check(out_valid == 1'b1, {"R4 strobe ", tag}, longint'(out_valid), 1);
    check(in_ready == 1'b1, {"R4 ready with result ", tag}, longint'(in_ready), 1);
    check(got() == e, {"R5 value ", tag}, got(), e);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    check(got() == 0, "R1 out_data", got(), 0);
    rst_n = 1'b1;

    // R8 impulse walks every tap of both groups, then steps and mixed (R5, R7)
    for (int v = 0; v < NVEC; v++) begin
      if (v < 8)       send(VEC[v], 1'b0, "R8 impulse");
      else if (v < 24) send(VEC[v], 1'b0, "R7 full-scale step");
      else             send(VEC[v], 1'b0, "R5 mixed");
    end

    // R4 out_data holds after the strobe
    begin
      longint held;
      held = got();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R4 strobe one cycle", longint'(out_valid), 0);
      check(got() == held, "R4 out_data holds", got(), held);
    end

    // R3 samples offered while busy are ignored
    send(8'sd40, 1'b1, "R3 junk while busy");
    send(-8'sd90, 1'b1, "R3 junk while busy");
    send(8'sd0, 1'b0, "R3 following output");

    // R7 alternating extremes
    send(-8'sd128, 1'b0, "R7 min");
    send(8'sd127, 1'b0, "R7 max");
    send(-8'sd128, 1'b0, "R7 min again");

    // R6 reset in the middle of a computation clears the tap line
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'sd111;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after mid reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after mid reset", longint'(in_ready), 1);
    check(got() == 0, "R1 out_data after mid reset", got(), 0);
    rst_n = 1'b1;
    clear_model();
    send(8'sd64, 1'b0, "R6 impulse after reset");
    for (int i = 1; i < TAPS; i++) send(8'sd0, 1'b0, "R6 zeros after reset");

    // R5 pseudo-random samples
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      send(seed[23:16], (i % 3) == 0, "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule